// File: doc/BRIEF.md
# Bidirectional Buffered Synchronous Serial Port

This block moves bytes over a two-wire synchronous link made of a shift clock line and a data line. Both lines are open-drain: the port only ever pulls a line low and reads back the resolved level. Several ports can therefore share one bus, with one port acting as master and the others listening. A single direction input picks the role. As a receiver, the port samples the data line on each rising edge of an external shift clock. After eight bits it places the byte in its data register and pulses an interrupt. As a transmitter, it makes the shift clock itself from a timer underflow strobe, so one bit takes two strobes. It sends the byte most significant bit first and pulses the interrupt after the eighth bit.

The data register sits in front of the shift register, so the transmitter is double-buffered. A byte written while another is being shifted waits as pending. It is taken into the shift register the moment the current byte ends, which keeps the stream free of gaps. Transmission only begins from idle when a byte is pending and the timer reports that it is running in continuous mode. When nothing is pending, the clock line rests high and the data line keeps the last bit sent. Changing direction aborts any byte in progress, in either direction.

Top module: `ssp_port`

## Requirements
- R1: After reset neither line is pulled low, the interrupt is low and the data register reads 0x00.
- R2: In receive mode (dir_out=0), each rising edge of the shift clock line shifts the data line level into the byte, with the first bit received landing in bit 7. On the eighth edge the byte appears on rd_data, and irq is high for exactly one cycle in the same cycle.
- R3: In receive mode the port never pulls either line low.
- R4: In transmit mode (dir_out=1), nothing leaves the port until a byte is written. A byte written while tmr_run is low produces no clock fall and no interrupt until tmr_run rises.
- R5: In transmit mode the clock line toggles once per underflow strobe. The data line changes only when the clock line falls. The byte is sent bit 7 first and is valid at each rising edge.
- R6: In transmit mode, irq pulses for one cycle after the eighth rising edge of each byte.
- R7: A byte written while another is being shifted follows it with no gap. The time from the last rising edge of one byte to the first rising edge of the next equals two underflow periods.
- R8: When a byte ends with nothing pending, the clock line returns high and stays high. The data line holds the level of bit 0 of that byte.
- R9: Changing direction aborts the byte in progress. Both lines are released, no interrupt is raised for the partial byte, and the next received byte starts again from its first bit.
- R10: rd_data returns the last byte written through wr_en/wr_data, or the last byte received, whichever came later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | 1 = transmit (port sources the clock), 0 = receive |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Data register contents |
| tmr_uflow | input | 1 | One-cycle timer underflow strobe |
| tmr_run | input | 1 | Timer running in continuous mode |
| clk_in | input | 1 | Resolved level of the shared clock line |
| dat_in | input | 1 | Resolved level of the shared data line |
| clk_drive_low | output | 1 | Pull the clock line low |
| dat_drive_low | output | 1 | Pull the data line low |
| irq | output | 1 | One-cycle byte-complete pulse |

## Verification
A received byte and its irq pulse are due three clock edges after the clock line rises: two synchroniser stages and then the data register. A transmit clock toggle is due one edge after the underflow strobe, and the data line moves on that same edge when the clock falls. A register write is visible on rd_data one edge after wr_en. The bench drives inputs one time unit after a rising edge and samples everything on the falling edge. Its monitor works from resolved bus-level events and the irq pulse rather than from fixed delays, so each byte is compared exactly when it completes. Gap, idle-level and abort checks are taken at points that are several underflow periods clear of any transition.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned SSP_W = 8;
  localparam int unsigned SSP_SYNC = 2;
  typedef enum logic [0:0] {TX_IDLE, TX_SHIFT} tx_state_e;
endpackage

// File: rtl/ssp_sync.sv
// Multi-bit level synchroniser for the resolved bus lines (idle high).
module ssp_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = ssp_pkg::SSP_SYNC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else if (g == 0) stage_q[g] <= async_in;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign level_o = stage_q[STAGES-1];
endmodule

// File: rtl/ssp_rx.sv
// Receive shifter: samples data on synchronised clock rising edges.
module ssp_rx #(
  parameter int unsigned W = ssp_pkg::SSP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         cnt_lvl,
  input  logic         sp_lvl,
  output logic         done,
  output logic [W-1:0] byte_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W-1);

  logic          prev_q, prev_d;
  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] bit_q, bit_d;
  logic          rise;

  assign rise   = en && cnt_lvl && !prev_q;
  assign byte_o = {sh_q[W-2:0], sp_lvl};
  assign done   = rise && (bit_q == LAST);

  always_comb begin
    prev_d = cnt_lvl;
    sh_d   = sh_q;
    bit_d  = bit_q;
    if (!en) begin
      bit_d = '0;
    end else if (rise) begin
      sh_d  = byte_o;
      bit_d = (bit_q == LAST) ? '0 : bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      sh_q   <= '0;
      bit_q  <= '0;
    end else begin
      prev_q <= prev_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
    end
  end

  p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (bit_q == '0));
endmodule

// File: rtl/ssp_tx.sv
// Transmit engine: clock from timer strobes, data moves on falling clock.
module ssp_tx
  import ssp_pkg::*;
#(
  parameter int unsigned W = SSP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         uflow,
  input  logic         tmr_run,
  input  logic         pending,
  input  logic [W-1:0] dreg,
  output logic         load,
  output logic         done,
  output logic         cnt_o,
  output logic         sp_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W-1);

  tx_state_e     state_q, state_d;
  logic          cnt_q, cnt_d;
  logic          sp_q, sp_d;
  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] bit_q, bit_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sp_d    = sp_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    load    = 1'b0;
    done    = 1'b0;
    if (!en) begin
      state_d = TX_IDLE;
      cnt_d   = 1'b1;
      bit_d   = '0;
    end else begin
      case (state_q)
        TX_IDLE: begin
          cnt_d = 1'b1;
          if (pending && tmr_run) begin
            load    = 1'b1;
            sh_d    = dreg;
            bit_d   = '0;
            state_d = TX_SHIFT;
          end
        end
        default: begin
          if (uflow) begin
            if (cnt_q) begin
              cnt_d = 1'b0;
              sp_d  = sh_q[W-1];
              sh_d  = sh_q << 1;
            end else begin
              cnt_d = 1'b1;
              if (bit_q == LAST) begin
                done  = 1'b1;
                bit_d = '0;
                if (pending) begin
                  load = 1'b1;
                  sh_d = dreg;
                end else begin
                  state_d = TX_IDLE;
                end
              end else begin
                bit_d = bit_q + 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= 1'b1;
      sp_q    <= 1'b1;
      sh_q    <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sp_q    <= sp_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
    end
  end

  assign cnt_o = cnt_q;
  assign sp_o  = sp_q;

  p_data_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_q) |-> $fell(cnt_q));
  p_cnt_needs_uflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$stable(cnt_q)) |-> $past(uflow));
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_IDLE) |-> cnt_q);
  p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == TX_IDLE && cnt_q));
endmodule

// File: rtl/ssp_port.sv
// Top: data register, pending flag, interrupt and open-drain line drives.
module ssp_port #(
  parameter int unsigned W = ssp_pkg::SSP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_out,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         tmr_uflow,
  input  logic         tmr_run,
  input  logic         clk_in,
  input  logic         dat_in,
  output logic         clk_drive_low,
  output logic         dat_drive_low,
  output logic         irq
);
  logic [1:0]   line_lvl;
  logic         rx_done, tx_done, tx_load, tx_cnt, tx_sp;
  logic [W-1:0] rx_byte;
  logic [W-1:0] dreg_q, dreg_d;
  logic         pend_q, pend_d;
  logic         irq_q, irq_d;

  ssp_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in({clk_in, dat_in}), .level_o(line_lvl)
  );

  ssp_rx #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(!dir_out), .cnt_lvl(line_lvl[1]),
    .sp_lvl(line_lvl[0]), .done(rx_done), .byte_o(rx_byte)
  );

  ssp_tx #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(dir_out), .uflow(tmr_uflow),
    .tmr_run(tmr_run), .pending(pend_q), .dreg(dreg_q), .load(tx_load),
    .done(tx_done), .cnt_o(tx_cnt), .sp_o(tx_sp)
  );

  always_comb begin
    dreg_d = dreg_q;
    if (wr_en) dreg_d = wr_data;
    else if (rx_done) dreg_d = rx_byte;

    pend_d = pend_q;
    if (!dir_out) pend_d = 1'b0;
    else if (wr_en) pend_d = 1'b1;
    else if (tx_load) pend_d = 1'b0;

    irq_d = rx_done || tx_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg_q <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      dreg_q <= dreg_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign rd_data       = dreg_q;
  assign irq           = irq_q;
  assign clk_drive_low = dir_out && !tx_cnt;
  assign dat_drive_low = dir_out && !tx_sp;

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_dreg_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> ($past(wr_en) || $past(rx_done)));
  p_pending_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !wr_en) |=> !pend_q);
endmodule

// File: tb/tb_ssp_port.sv
module tb_ssp_port;
  localparam int UF = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_out = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tmr_uflow = 1'b0;
  logic       tmr_run = 1'b0;
  logic       clk_drive_low, dat_drive_low, irq;
  logic       mstr_cnt = 1'b1, mstr_sp = 1'b1;
  logic       cnt_bus, sp_bus;
  logic       uf_on = 1'b0;

  int checks = 0, fails = 0;
  int cyc = 0, tx_falls = 0, irq_cnt = 0, r3_viol = 0;
  int gap_checks = 0;
  bit gap_arm = 0, finished = 0;
  logic [7:0] rx_q[$];
  logic [7:0] tx_q[$];

  assign cnt_bus = mstr_cnt & ~clk_drive_low;
  assign sp_bus  = mstr_sp & ~dat_drive_low;

  ssp_port dut (
    .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tmr_uflow(tmr_uflow),
    .tmr_run(tmr_run), .clk_in(cnt_bus), .dat_in(sp_bus),
    .clk_drive_low(clk_drive_low), .dat_drive_low(dat_drive_low), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // underflow strobe source
  initial begin
    forever begin
      repeat (UF - 1) @(posedge clk);
      #1 tmr_uflow = uf_on;
      @(posedge clk);
      #1 tmr_uflow = 1'b0;
    end
  end

  // monitor / scoreboard
  logic       prev_cnt = 1'b1;
  logic [7:0] asm_byte = 8'h00;
  int         asm_bits = 0, last_rise = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (irq) begin
        irq_cnt++;
        if (!dir_out) begin
          if (rx_q.size() == 0) chk(0, "R2 unexpected rx byte", rd_data, 0);
          else begin
            logic [7:0] e;
            e = rx_q.pop_front();
            chk(rd_data == e, "R2 rx byte", rd_data, e);
          end
        end
      end
      if (!dir_out && (clk_drive_low || dat_drive_low)) r3_viol++;
      if (!dir_out) asm_bits = 0;
      else begin
        if (prev_cnt && !cnt_bus) tx_falls++;
        if (!prev_cnt && cnt_bus) begin
          if (asm_bits == 0 && gap_arm) begin
            chk(cyc - last_rise == 2 * UF, "R7 gap", cyc - last_rise, 2 * UF);
            gap_arm = 0;
            gap_checks++;
          end
          last_rise = cyc;
          asm_byte = {asm_byte[6:0], sp_bus};
          asm_bits++;
          if (asm_bits == 8) begin
            asm_bits = 0;
            if (tx_q.size() == 0) chk(0, "R5 unexpected tx byte", asm_byte, 0);
            else begin
              logic [7:0] e;
              e = tx_q.pop_front();
              chk(asm_byte == e, "R5 tx byte", asm_byte, e);
            end
          end
        end
      end
      prev_cnt = cnt_bus;
    end
  end

  task automatic send_rx(input logic [7:0] b, input int nbits, input bit expect_it);
    if (expect_it) rx_q.push_back(b);
    for (int i = 7; i > 7 - nbits; i--) begin
      #1 mstr_sp = b[i]; mstr_cnt = 1'b0;
      repeat (4) @(posedge clk);
      #1 mstr_cnt = 1'b1;
      repeat (4) @(posedge clk);
    end
    #1 mstr_sp = 1'b1;
    repeat (6) @(posedge clk);
  endtask

  task automatic write(input logic [7:0] v);
    @(posedge clk);
    #1 wr_en = 1'b1; wr_data = v;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic drain();
    while (tx_q.size() != 0) @(posedge clk);
    repeat (3 * UF) @(posedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!clk_drive_low && !dat_drive_low, "R1 lines", {clk_drive_low, dat_drive_low}, 0);
    chk(!irq, "R1 irq", irq, 0);
    chk(rd_data == 8'h00, "R1 data", rd_data, 0);

    // receive: R2, R3
    send_rx(8'hA5, 8, 1);
    send_rx(8'h3C, 8, 1);
    // R9: partial byte aborted by direction change
    send_rx(8'hF0, 3, 0);
    @(posedge clk); #1 dir_out = 1'b1;
    repeat (3) @(posedge clk); #1 dir_out = 1'b0;
    repeat (3) @(posedge clk);
    send_rx(8'h96, 8, 1);
    chk(rx_q.size() == 0, "R2 all rx bytes", rx_q.size(), 0);
    chk(r3_viol == 0, "R3 no drive in receive", r3_viol, 0);

    // transmit gating: R4, R10
    @(posedge clk); #1 dir_out = 1'b1; uf_on = 1'b1;
    base = irq_cnt;
    write(8'h7E);
    @(negedge clk);
    chk(rd_data == 8'h7E, "R10 write readback", rd_data, 8'h7E);
    repeat (20 * UF) @(posedge clk);
    chk(tx_falls == 0, "R4 no clock without run", tx_falls, 0);
    chk(irq_cnt == base, "R4 no irq without run", irq_cnt, base);
    tx_q.push_back(8'h7E);
    #1 tmr_run = 1'b1;
    drain();
    chk(irq_cnt == base + 1, "R6 one irq per byte", irq_cnt, base + 1);
    @(negedge clk);
    chk(!clk_drive_low, "R8 clock high at idle", clk_drive_low, 0);
    chk(dat_drive_low, "R8 data holds bit0=0", dat_drive_low, 1);
    repeat (4 * UF) @(posedge clk);
    @(negedge clk);
    chk(!clk_drive_low && dat_drive_low, "R8 idle stays", {clk_drive_low, dat_drive_low}, 1);

    // gapless pair: R7
    base = irq_cnt;
    tx_q.push_back(8'h5A);
    tx_q.push_back(8'hC3);
    write(8'h5A);
    repeat (3 * UF) @(posedge clk);
    gap_arm = 1;
    write(8'hC3);
    drain();
    chk(gap_checks == 1, "R7 gap measured", gap_checks, 1);
    chk(irq_cnt == base + 2, "R6 two irqs for pair", irq_cnt, base + 2);
    @(negedge clk);
    chk(!clk_drive_low && !dat_drive_low, "R8 data holds bit0=1", {clk_drive_low, dat_drive_low}, 0);

    // abort in transmit: R9
    base = irq_cnt;
    write(8'h00);
    repeat (5 * UF) @(posedge clk);
    #1 dir_out = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!clk_drive_low && !dat_drive_low, "R9 lines released", {clk_drive_low, dat_drive_low}, 0);
    repeat (30 * UF) @(posedge clk);
    chk(irq_cnt == base, "R9 no irq for partial", irq_cnt, base);
    chk(tx_q.size() == 0, "R5 all tx bytes", tx_q.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule